// File: doc/BRIEF.md
# MDIO Management Master Controller

This block is a register-controlled master for the two-wire PHY management bus. It sends clause-22 management frames to external PHY devices. Software sets up the clock divider and the enable bit in a control word. It then writes a transfer word with the start bit set, naming the PHY, the register and, for a write, the data. The start bit stays high while the frame is on the wire. It clears by itself when the frame ends. At that point a read transfer holds the returned 16-bit value and an acknowledge flag.

A bypass mode gives the clock, data-output and output-enable pins to three bits of a pin register, so that software can bit-bang the bus. In this mode the sampled data input can be read back on bit 0 of that register. The register port is a single-cycle write strobe with a 2-bit word address and a combinational read path. Word 0 is the control word, word 1 the transfer word, word 2 the mode word and word 3 the pin word.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset the control word reads with idle (bit 31) = 1, enable (bit 30) = 0 and the divider (bits 15:0) at its reset parameter value. The transfer word reads 0.
- R2: A write transfer (transfer bit 30 = 1) puts 64 driven bits on the data pin, most significant first: 32 ones, start 01, opcode 01, the 5-bit PHY address (bits 20:16), the 5-bit register address (bits 25:21), turnaround 10, then the 16 data bits (bits 15:0).
- R3: A read transfer (bit 30 = 0) sends opcode 10 and drives the output enable low for the last 18 bit times (turnaround plus data). The 16 bits sampled during the data phase land in transfer bits 15:0, first-received bit as bit 15.
- R4: A read sets the acknowledge flag (transfer bit 29) only when the PHY holds the input low during the second turnaround bit. Otherwise the flag reads 0.
- R5: The start bit (transfer bit 31) reads 1 from the write that sets it until the frame completes, then reads 0.
- R6: A write to the transfer word while its start bit is still 1 changes no field of it.
- R7: One clock period equals divider + 1 input clock cycles. A divider of 0 is treated as 1.
- R8: When mode bit 31 = 1, the clock pin follows pin-word bit 2, output enable follows bit 1 and data output follows bit 0. Reads of pin-word bit 0 return the data input.
- R9: Clearing enable lets a running frame finish, after which idle reads 1. While enable is 0, a pending start bit launches no frame and the clock pin stays low.
- R10: The data output changes only while the clock pin is low. The input is sampled on the clock's rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mdc | output | 1 | Management clock pin |
| mdio_o | output | 1 | Data pin output value |
| mdio_oe | output | 1 | Data pin output enable |
| mdio_i | input | 1 | Data pin input value |

## Verification
The assertions check, on every cycle, rules about state that several parts of the block share. While a frame runs the start bit is held, and a finished frame clears it. Writes made while a frame runs leave the transfer fields unchanged. A disabled engine never starts, and the data output stays put while the clock is high. The bench scenarios are needed to show the exact bit order on the wire, the release of the line on reads, the captured read data and acknowledge, and the clock period for even, odd and zero dividers. They also cover the bypass pin mapping and a frame that finishes after enable is cleared.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
   localparam int unsigned ADDR_W = 5;
   localparam int unsigned DATA_W = 16;

   typedef enum logic [1:0] {
      RA_CTRL = 2'd0,
      RA_XFER = 2'd1,
      RA_MODE = 2'd2,
      RA_PINS = 2'd3
   } reg_sel_e;

   typedef struct packed {
      logic              wr;
      logic [ADDR_W-1:0] regad;
      logic [ADDR_W-1:0] phy;
      logic [DATA_W-1:0] data;
   } xfer_t;
endpackage

// File: rtl/mdio_in_sync.sv
module mdio_in_sync #(
   parameter int unsigned STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   generate
      if (STAGES == 0) begin : g_direct
         assign dout = din;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else if (STAGES == 1) chain <= din;
            else chain <= {chain[STAGES-2:0], din};
         end
         assign dout = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
   import mdio_mgmt_pkg::*;
#(
   parameter int unsigned PRE_LEN = 32,
   parameter int unsigned DIV_W   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  xfer_t             xfer,
   input  logic [DIV_W-1:0]  div,
   output logic              busy,
   output logic              done,
   output logic              mdc,
   output logic              mdo,
   output logic              moe,
   input  logic              mdi,
   output logic              ack,
   output logic [DATA_W-1:0] rdata
);
   localparam int unsigned FLEN  = PRE_LEN + 32;
   localparam int unsigned IDX_W = $clog2(FLEN);
   localparam int unsigned TA1   = PRE_LEN + 14;
   localparam int unsigned TA2   = PRE_LEN + 15;
   localparam int unsigned DSTRT = PRE_LEN + 16;
   localparam int unsigned LAST  = FLEN - 1;

   initial begin
      assert (PRE_LEN >= 1) else $error("preamble length must be at least 1");
      assert (DIV_W >= 1 && DIV_W <= 16) else $error("divider width out of range");
   end

   logic [DIV_W:0]   eff, half, ph;
   logic [IDX_W-1:0] idx;
   logic [FLEN-1:0]  sh, load;
   logic             wr_q;

   assign eff  = (div == '0) ? (DIV_W+1)'(1) : {1'b0, div};
   assign half = (eff + (DIV_W+1)'(1)) >> 1;

   assign load = {{PRE_LEN{1'b1}}, 2'b01,
                  xfer.wr ? 2'b01 : 2'b10,
                  xfer.phy, xfer.regad,
                  xfer.wr ? 2'b10 : 2'b11,
                  xfer.wr ? xfer.data : {DATA_W{1'b1}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         done  <= 1'b0;
         idx   <= '0;
         ph    <= '0;
         sh    <= '1;
         wr_q  <= 1'b0;
         ack   <= 1'b0;
         rdata <= '0;
      end else begin
         done <= 1'b0;
         if (start && !busy) begin
            busy  <= 1'b1;
            idx   <= '0;
            ph    <= '0;
            sh    <= load;
            wr_q  <= xfer.wr;
            ack   <= 1'b0;
            rdata <= '0;
         end else if (busy) begin
            if (ph == half) begin
               if (idx == IDX_W'(TA2)) ack <= ~mdi;
               if (idx >= IDX_W'(DSTRT)) rdata <= {rdata[DATA_W-2:0], mdi};
            end
            if (ph == eff) begin
               ph <= '0;
               if (idx == IDX_W'(LAST)) begin
                  busy <= 1'b0;
                  done <= 1'b1;
               end else begin
                  idx <= idx + IDX_W'(1);
                  sh  <= {sh[FLEN-2:0], 1'b1};
               end
            end else begin
               ph <= ph + (DIV_W+1)'(1);
            end
         end
      end
   end

   assign mdc = busy && (ph >= half);
   assign mdo = sh[FLEN-1];
   assign moe = busy && (wr_q || (idx < IDX_W'(TA1)));

   // R10: the data pin holds its value while the clock is high
   p_mdo_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && mdc && $past(busy) && $past(mdc)) |-> $stable(mdo));
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
   import mdio_mgmt_pkg::*;
#(
   parameter int unsigned        PRE_LEN   = 32,
   parameter int unsigned        DIV_W     = 16,
   parameter int unsigned        SYNC_STGS = 0,
   parameter logic [DIV_W-1:0]   DIV_RST   = DIV_W'(9)
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic [1:0]  reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   output logic        mdc,
   output logic        mdio_o,
   output logic        mdio_oe,
   input  logic        mdio_i
);
   logic              en_r, man_r, go_r, ack_r;
   logic [DIV_W-1:0]  div_r;
   logic [2:0]        pin_r;
   xfer_t             xf_r;
   logic              e_busy, e_done, e_mdc, e_mdo, e_moe, e_ack, mdi_s, start;
   logic [DATA_W-1:0] e_rdata;
   logic              idle;
   logic              unused_wbits;

   assign unused_wbits = ^reg_wdata[29:26];

   mdio_in_sync #(.STAGES(SYNC_STGS)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(mdio_i), .dout(mdi_s));

   assign start = go_r && en_r && !man_r && !e_busy && !e_done;

   mdio_frame_eng #(.PRE_LEN(PRE_LEN), .DIV_W(DIV_W)) u_eng (
      .clk(clk), .rst_n(rst_n), .start(start), .xfer(xf_r), .div(div_r),
      .busy(e_busy), .done(e_done), .mdc(e_mdc), .mdo(e_mdo), .moe(e_moe),
      .mdi(mdi_s), .ack(e_ack), .rdata(e_rdata));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_r  <= 1'b0;
         man_r <= 1'b0;
         go_r  <= 1'b0;
         ack_r <= 1'b0;
         div_r <= DIV_RST;
         pin_r <= 3'b000;
         xf_r  <= '0;
      end else begin
         if (e_done) begin
            go_r <= 1'b0;
            if (!xf_r.wr) begin
               xf_r.data <= e_rdata;
               ack_r     <= e_ack;
            end
         end
         if (reg_wr) begin
            unique case (reg_sel_e'(reg_addr))
               RA_CTRL: begin
                  en_r  <= reg_wdata[30];
                  div_r <= reg_wdata[DIV_W-1:0];
               end
               RA_XFER: if (!go_r) begin
                  go_r  <= reg_wdata[31];
                  ack_r <= 1'b0;
                  xf_r  <= '{wr: reg_wdata[30], regad: reg_wdata[25:21],
                             phy: reg_wdata[20:16], data: reg_wdata[15:0]};
               end
               RA_MODE: man_r <= reg_wdata[31];
               RA_PINS: pin_r <= reg_wdata[2:0];
               default: ;
            endcase
         end
      end
   end

   assign idle = !en_r && !e_busy;

   always_comb begin
      unique case (reg_sel_e'(reg_addr))
         RA_CTRL: reg_rdata = {idle, en_r, 30'(div_r)};
         RA_XFER: reg_rdata = {go_r, xf_r.wr, ack_r, 3'b000,
                               xf_r.regad, xf_r.phy, xf_r.data};
         RA_MODE: reg_rdata = {man_r, 31'd0};
         RA_PINS: reg_rdata = {29'd0, pin_r[2:1], mdi_s};
         default: reg_rdata = '0;
      endcase
   end

   assign mdc     = man_r ? pin_r[2] : e_mdc;
   assign mdio_oe = man_r ? pin_r[1] : e_moe;
   assign mdio_o  = man_r ? pin_r[0] : e_mdo;

   // R5: a running frame keeps the start bit high
   p_go_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
      e_busy |-> go_r);
   // R5: a completed frame clears the start bit on the next cycle
   p_done_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      e_done |=> !go_r);
   // R6: writes while the start bit is set leave the transfer fields alone
   p_busy_write_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 2'd1 && go_r && !e_done) |=> ($stable(xf_r) && go_r));
   // R9: a disabled, quiet engine stays quiet
   p_off_stays_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_r && !e_busy) |=> !e_busy);
   // R9: a frame only begins from an enabled, non-bypass state
   p_start_needs_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(e_busy) |-> ($past(en_r) && !$past(man_r)));
endmodule

// File: tb/mdio_mgmt_master_tb.sv
module mdio_mgmt_master_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mdc, mdio_o, mdio_oe, mdio_i;

   logic        man_test = 1'b0, man_val = 1'b1, phy_drv = 1'b1;
   assign mdio_i = man_test ? man_val : phy_drv;

   int errors = 0, checks = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   mdio_mgmt_master u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
      .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // scoreboard state
   logic [63:0] exp_frm[$], exp_oe[$];
   logic [63:0] cap, capoe, resp;
   bit          mon_on = 0;
   int          k = 0, cyc = 0, last_rise = 0, period = 0, rises = 0, bad_chg = 0;
   logic        prev_mdc = 0, prev_o = 0;

   always @(posedge clk) cyc++;

   always @(negedge clk) begin
      if (mon_on && mdc && prev_mdc && (mdio_o !== prev_o)) bad_chg++;
      prev_mdc = mdc;
      prev_o   = mdio_o;
   end

   // monitor: capture each bit on the clock's rising edge
   always @(posedge mdc) begin
      rises++;
      if (mon_on && k < 64) begin
         if (k > 0) period = cyc - last_rise;
         last_rise = cyc;
         cap[63-k]   = mdio_o;
         capoe[63-k] = mdio_oe;
         k++;
         if (k == 64) begin
            logic [63:0] ef, eo;
            ef = exp_frm.pop_front();
            eo = exp_oe.pop_front();
            check(capoe == eo, "R2/R3 output-enable pattern", capoe, eo);
            check(((cap ^ ef) & eo) == 64'd0, "R2 driven frame bits", cap & eo, ef & eo);
         end
      end
   end

   // PHY model: present the next bit after each falling edge
   always @(negedge mdc) if (mon_on && k < 64) phy_drv = resp[63-k];

   task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic wait_go_clear();
      logic [31:0] v;
      for (int i = 0; i < 20000; i++) begin
         rd_reg(2'd1, v);
         if (!v[31]) return;
      end
      check(1'b0, "R5 start bit never cleared", 64'(v), 64'd0);
   endtask

   // driver: push the expected wire image, then launch
   task automatic launch(input bit wr, input logic [4:0] phy, input logic [4:0] ra,
                         input logic [15:0] d, input bit pack, input logic [15:0] pdata);
      logic [63:0] f;
      f = {32'hFFFF_FFFF, 2'b01, wr ? 2'b01 : 2'b10, phy, ra, 2'b10, d};
      exp_frm.push_back(f);
      exp_oe.push_back(wr ? 64'hFFFF_FFFF_FFFF_FFFF : ~64'h3FFFF);
      resp = {32'hFFFF_FFFF, 15'h7FFF, ~pack, pdata};
      phy_drv = 1'b1;
      k = 0;
      mon_on = 1;
      wr_reg(2'd1, {1'b1, wr, 4'b0000, ra, phy, d});
   endtask

   initial begin
      logic [31:0] v;
      int r0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset values
      rd_reg(2'd0, v);
      check(v == 32'h8000_0009, "R1 control after reset", 64'(v), 64'h8000_0009);
      rd_reg(2'd1, v);
      check(v == 32'd0, "R1 transfer after reset", 64'(v), 64'd0);

      // R2 write frame, divider 3
      wr_reg(2'd0, 32'h4000_0003);
      launch(1'b1, 5'd5, 5'h12, 16'hA5C3, 1'b0, 16'h0);
      rd_reg(2'd1, v);
      check(v[31] == 1'b1, "R5 start bit high while running", 64'(v[31]), 64'd1);
      rd_reg(2'd0, v);
      check(v[31] == 1'b0, "R9 idle low while enabled", 64'(v[31]), 64'd0);
      wait_go_clear();
      check(period == 4, "R7 clock period divider 3", 64'(period), 64'd4);
      rd_reg(2'd1, v);
      check(v == {6'b010000, 5'h12, 5'd5, 16'hA5C3}, "R5 transfer word after write", 64'(v),
            64'({6'b010000, 5'h12, 5'd5, 16'hA5C3}));

      // R3/R4 read with acknowledge, divider 4
      wr_reg(2'd0, 32'h4000_0004);
      launch(1'b0, 5'h1F, 5'h00, 16'h0, 1'b1, 16'h3C5A);
      wait_go_clear();
      check(period == 5, "R7 clock period divider 4", 64'(period), 64'd5);
      rd_reg(2'd1, v);
      check(v[15:0] == 16'h3C5A, "R3 read data captured", 64'(v[15:0]), 64'h3C5A);
      check(v[29] == 1'b1, "R4 acknowledge set", 64'(v[29]), 64'd1);

      // R4 no acknowledge, divider 0 clamps to 1
      wr_reg(2'd0, 32'h4000_0000);
      launch(1'b0, 5'h03, 5'h07, 16'h0, 1'b0, 16'h8001);
      wait_go_clear();
      check(period == 2, "R7 clock period divider 0", 64'(period), 64'd2);
      rd_reg(2'd1, v);
      check(v[29] == 1'b0, "R4 acknowledge clear", 64'(v[29]), 64'd0);
      check(v[15:0] == 16'h8001, "R3 read data second pattern", 64'(v[15:0]), 64'h8001);

      // R6 write during a frame
      wr_reg(2'd0, 32'h4000_0002);
      launch(1'b1, 5'd1, 5'd9, 16'h1234, 1'b0, 16'h0);
      repeat (20) @(negedge clk);
      wr_reg(2'd1, {1'b1, 1'b0, 4'b0000, 5'd30, 5'd2, 16'h0000});
      wait_go_clear();
      rd_reg(2'd1, v);
      check(v == {6'b010000, 5'd9, 5'd1, 16'h1234}, "R6 busy write ignored", 64'(v),
            64'({6'b010000, 5'd9, 5'd1, 16'h1234}));

      // R8 bypass mode
      mon_on = 0;
      wr_reg(2'd2, 32'h8000_0000);
      wr_reg(2'd3, 32'h0000_0006);
      #1 check({mdc, mdio_oe, mdio_o} == 3'b110, "R8 pins follow 110", 64'({mdc, mdio_oe, mdio_o}), 64'd6);
      wr_reg(2'd3, 32'h0000_0003);
      #1 check({mdc, mdio_oe, mdio_o} == 3'b011, "R8 pins follow 011", 64'({mdc, mdio_oe, mdio_o}), 64'd3);
      man_test = 1'b1; man_val = 1'b0;
      rd_reg(2'd3, v);
      check(v[0] == 1'b0, "R8 input readback low", 64'(v[0]), 64'd0);
      man_val = 1'b1;
      rd_reg(2'd3, v);
      check(v[0] == 1'b1, "R8 input readback high", 64'(v[0]), 64'd1);
      man_test = 1'b0;
      wr_reg(2'd3, 32'h0);
      wr_reg(2'd2, 32'h0);

      // R9 disable mid-frame, then pending start with enable off
      wr_reg(2'd0, 32'h4000_0003);
      launch(1'b0, 5'd4, 5'd2, 16'h0, 1'b1, 16'h00FF);
      repeat (30) @(negedge clk);
      wr_reg(2'd0, 32'h0000_0003);
      rd_reg(2'd0, v);
      check(v[31] == 1'b0, "R9 idle low while frame finishes", 64'(v[31]), 64'd0);
      wait_go_clear();
      rd_reg(2'd0, v);
      check(v[31] == 1'b1, "R9 idle after disabled frame", 64'(v[31]), 64'd1);
      rd_reg(2'd1, v);
      check(v[15:0] == 16'h00FF, "R9 disabled frame completed read", 64'(v[15:0]), 64'h00FF);
      mon_on = 0;
      r0 = rises;
      wr_reg(2'd1, {1'b1, 1'b1, 4'b0000, 5'd1, 5'd1, 16'h5555});
      repeat (100) @(negedge clk);
      check(rises == r0, "R9 no clock while disabled", 64'(rises - r0), 64'd0);
      rd_reg(2'd0, v);
      check(v[31] == 1'b1, "R9 idle stays high", 64'(v[31]), 64'd1);

      check(bad_chg == 0, "R10 data steady while clock high", 64'(bad_chg), 64'd0);
      check(exp_frm.size() == 0, "R2 all frames observed", 64'(exp_frm.size()), 64'd0);

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule